// File: doc/BRIEF.md
# Power Sequencer Instruction Engine

This block is a small microcoded sequencer of the kind that drives a power-management state machine. A pulse on `start` loads the program counter from `entry_pc`. From then on the engine fetches one 32-bit instruction per cycle from an external program memory. The memory read is combinational: `imem_rdata` answers `imem_addr` in the same cycle. Each instruction acts on an internal file of 8-bit registers and on a small set of scratch registers.

The instruction set covers:
- masked and full register writes;
- scratch loads and scratch-sourced masked writes;
- fixed and scratch-sourced delays, with a programmable delay step;
- a wait that branches only forward;
- end.

A wait whose timeout field is zero tests its condition once and behaves as an if-test. A non-zero timeout turns it into a timed poll. An unconditional jump is a wait on the constant-false condition. Software observes the register file through a read port. `busy`, `done` and `error` report the run state.

Top module: `pseq_engine`

## Requirements
- R1: After reset, `busy`, `done` and `error` are low and every register reads 0 through `rf_raddr`/`rf_rdata`.
- R2: Opcode 1 is the masked immediate write: register [19:16] becomes (old AND mask[7:0]) OR (data[15:8] AND NOT mask). A mask bit of 1 keeps the old bit, so data 0x01 with mask 0xFE changes only bit 0.
- R3: Opcode 2 overwrites all eight bits of register [19:16] with data [15:8].
- R4: Every non-delay instruction takes exactly one cycle. A masked write whose mask is 0xFF leaves the register unchanged and costs one cycle.
- R5: Opcode 3 copies register [19:16] into scratch [25:24]. Opcode 4 loads scratch [25:24] with [15:8]. Opcode 5 is a masked write to register [19:16] that takes its data from scratch [25:24], using the R2 rule.
- R6: Opcode 8 sets the step exponent k from [3:0], so one step is 2^k cycles. Opcode 6 delays for [15:0] cycles, which adds that many cycles after its own cycle. When [15:0] is not a multiple of 2^k, or exceeds 255 steps, the delay is rejected: `error` rises and nothing further runs.
- R7: Opcode 7 delays for (scratch [25:24]) × 2^k cycles after its own cycle.
- R8: Opcode 9 is the wait. Its fields are: condition select [23:20], indexing `cond_in`; timeout in steps [15:8]; skip [7:0]. The branch target is pc+1+skip. With timeout 0 the condition is tested once: if true the engine falls through to pc+1, otherwise it branches.
- R9: With a non-zero timeout T, the wait falls through in the first cycle the condition is true. If the condition stays false, the engine branches after 1+T×2^k cycles.
- R10: Condition select 15 is constant false, so a zero-timeout wait with select 15 always jumps forward, whatever `cond_in` holds.
- R11: Opcode 0 ends the run: `busy` falls and `done` pulses for exactly one cycle.
- R12: The engine halts with `error` high and `done` low when any of these occurs:
  - the next pc would exceed the last program address; a write at that address still takes effect;
  - an opcode above 9 is fetched;
  - bits [27:26] are non-zero.
- R13: `start` is accepted only while idle, and it clears `error`. A `start` during a run has no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run at `entry_pc` when idle |
| entry_pc | input | PC_W | Program entry address |
| imem_addr | output | PC_W | Program memory address (current pc) |
| imem_rdata | input | 32 | Instruction at `imem_addr`, same cycle |
| cond_in | input | NCOND | Monitored status conditions |
| rf_raddr | input | RA_W | Register file read address |
| rf_rdata | output | 8 | Register file read data |
| busy | output | 1 | Program running |
| done | output | 1 | One-cycle pulse on end |
| error | output | 1 | Run halted on a fault; held until next start |

## Verification
Some properties are checked on every cycle:
- the one-cycle shape of `done`;
- `error` and `done` only ever appear while idle;
- a start loads the entry address;
- a fall-through moves the pc by exactly one;
- a branch always moves the pc forward;
- the pc stays still while a delay counts down.

Other behaviour can only be shown by the bench's programs:
- the masking arithmetic, checked through the read port;
- the exact cycle cost of delays and timed waits for several step sizes;
- rejection of unreachable delays;
- a condition rising in the middle of a poll;
- the three ways a run can fault.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

  localparam int INSTR_W = 32;
  localparam int DATA_W  = 8;
  localparam int STEP_W  = 4;
  localparam int CNT_W   = 8;
  localparam int CYC_W   = CNT_W + (1 << STEP_W) - 1;

  typedef enum logic [3:0] {
    OP_END  = 4'd0,
    OP_WMI  = 4'd1,
    OP_WI   = 4'd2,
    OP_SRD  = 4'd3,
    OP_SWI  = 4'd4,
    OP_WMS  = 4'd5,
    OP_DLI  = 4'd6,
    OP_DLS  = 4'd7,
    OP_STEP = 4'd8,
    OP_WAIT = 4'd9
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DELAY,
    ST_WAIT
  } st_e;

  typedef struct packed {
    op_e               op;
    logic              legal;
    logic [1:0]        sidx;
    logic [3:0]        csel;
    logic [3:0]        raddr;
    logic [DATA_W-1:0] data;
    logic [DATA_W-1:0] mask;
    logic [15:0]       ticks;
    logic [STEP_W-1:0] expo;
    logic [CNT_W-1:0]  tmo;
    logic [7:0]        skip;
  } dec_t;

  // keep bits where mask is 1, take new data where mask is 0
  function automatic logic [DATA_W-1:0] mask_merge(input logic [DATA_W-1:0] old,
                                                   input logic [DATA_W-1:0] dat,
                                                   input logic [DATA_W-1:0] msk);
    return (old & msk) | (dat & ~msk);
  endfunction

  // a cycle count is reachable when it is a whole number of steps that fits the step counter
  function automatic logic delay_reachable(input logic [15:0] cyc,
                                           input logic [STEP_W-1:0] k);
    logic [15:0] low;
    low = (16'd1 << k) - 16'd1;
    return ((cyc & low) == 16'd0) && ((cyc >> k) <= 16'((1 << CNT_W) - 1));
  endfunction

  function automatic logic [CYC_W-1:0] steps_to_cycles(input logic [CNT_W-1:0] n,
                                                       input logic [STEP_W-1:0] k);
    return CYC_W'(n) << k;
  endfunction

endpackage

// File: rtl/pseq_regfile.sv
module pseq_regfile #(
  parameter int N  = 16,
  parameter int W  = 8,
  parameter int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);

  logic [W-1:0] mem [N];

  for (genvar i = 0; i < N; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[i] <= '0;
      end else if (we && (waddr == AW'(i))) begin
        mem[i] <= wdata;
      end
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/pseq_timer.sv
module pseq_timer #(
  parameter int W = 23
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         last
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= val;
    end else if (cnt != '0) begin
      cnt <= cnt - W'(1);
    end
  end

  assign last = (cnt == W'(1));

endmodule

// File: rtl/pseq_decode.sv
module pseq_decode
  import pseq_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               d
);

  always_comb begin
    d.op    = op_e'(instr[31:28]);
    d.legal = (instr[31:28] <= 4'd9) && (instr[27:26] == 2'b00);
    d.sidx  = instr[25:24];
    d.csel  = instr[23:20];
    d.raddr = instr[19:16];
    d.data  = instr[15:8];
    d.mask  = instr[7:0];
    d.ticks = instr[15:0];
    d.expo  = instr[STEP_W-1:0];
    d.tmo   = instr[15:8];
    d.skip  = instr[7:0];
  end

endmodule

// File: rtl/pseq_engine.sv
module pseq_engine
  import pseq_pkg::*;
#(
  parameter  int PROG_DEPTH = 64,
  parameter  int NREG       = 16,
  parameter  int NSCR       = 4,
  parameter  int NCOND      = 8,
  localparam int PC_W       = $clog2(PROG_DEPTH),
  localparam int RA_W       = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [PC_W-1:0]    entry_pc,
  output logic [PC_W-1:0]    imem_addr,
  input  logic [INSTR_W-1:0] imem_rdata,
  input  logic [NCOND-1:0]   cond_in,
  input  logic [RA_W-1:0]    rf_raddr,
  output logic [DATA_W-1:0]  rf_rdata,
  output logic               busy,
  output logic               done,
  output logic               error
);

  localparam int SC_W = $clog2(NSCR);
  localparam int NW   = PC_W + 9;
  localparam int LAST = PROG_DEPTH - 1;

  st_e               st;
  logic [PC_W-1:0]   pc;
  logic [STEP_W-1:0] step_k;
  logic              done_q, err_q;
  dec_t              d;

  logic              rf_we, sc_we, k_we;
  logic [DATA_W-1:0] rf_wd, sc_wd, rf_old, sc_a, sc_b;
  logic              go_seq, go_br, go_bad, go_end, nx_delay, nx_wait;
  logic              tm_load, tm_last;
  logic [CYC_W-1:0]  tm_val;
  logic [15:0]       cond_ext;
  logic              cond_hit;
  logic [NW-1:0]     seq_nx, br_nx, nx;
  logic              nx_ok;

  // events brought out for the checker
  logic ev_fall, ev_branch, in_delay;

  pseq_decode u_dec (.instr(imem_rdata), .d(d));

  pseq_regfile #(.N(NREG), .W(DATA_W)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(rf_we), .waddr(d.raddr[RA_W-1:0]), .wdata(rf_wd),
    .raddr_a(d.raddr[RA_W-1:0]), .rdata_a(rf_old),
    .raddr_b(rf_raddr), .rdata_b(rf_rdata)
  );

  // port a feeds scratch-sourced writes, port b feeds scratch-sourced delays
  pseq_regfile #(.N(NSCR), .W(DATA_W)) u_scr (
    .clk(clk), .rst_n(rst_n),
    .we(sc_we), .waddr(d.sidx[SC_W-1:0]), .wdata(sc_wd),
    .raddr_a(d.sidx[SC_W-1:0]), .rdata_a(sc_a),
    .raddr_b(d.sidx[SC_W-1:0]), .rdata_b(sc_b)
  );

  pseq_timer #(.W(CYC_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tm_load), .val(tm_val), .last(tm_last)
  );

  // select 15 and any select beyond the implemented inputs read as false
  assign cond_ext = {{(16 - NCOND){1'b0}}, cond_in};
  assign cond_hit = cond_ext[d.csel];

  assign seq_nx = NW'(pc) + NW'(1);
  assign br_nx  = NW'(pc) + NW'(d.skip) + NW'(1);
  assign nx     = go_br ? br_nx : seq_nx;
  assign nx_ok  = (nx <= NW'(LAST));

  always_comb begin
    rf_we    = 1'b0;
    rf_wd    = rf_old;
    sc_we    = 1'b0;
    sc_wd    = d.data;
    k_we     = 1'b0;
    go_seq   = 1'b0;
    go_br    = 1'b0;
    go_bad   = 1'b0;
    go_end   = 1'b0;
    nx_delay = 1'b0;
    nx_wait  = 1'b0;
    tm_load  = 1'b0;
    tm_val   = '0;
    unique case (st)
      ST_RUN: begin
        if (!d.legal) begin
          go_bad = 1'b1;
        end else begin
          unique case (d.op)
            OP_END: go_end = 1'b1;
            OP_WMI: begin
              rf_we  = 1'b1;
              rf_wd  = mask_merge(rf_old, d.data, d.mask);
              go_seq = 1'b1;
            end
            OP_WI: begin
              rf_we  = 1'b1;
              rf_wd  = d.data;
              go_seq = 1'b1;
            end
            OP_SRD: begin
              sc_we  = 1'b1;
              sc_wd  = rf_old;
              go_seq = 1'b1;
            end
            OP_SWI: begin
              sc_we  = 1'b1;
              go_seq = 1'b1;
            end
            OP_WMS: begin
              rf_we  = 1'b1;
              rf_wd  = mask_merge(rf_old, sc_a, d.mask);
              go_seq = 1'b1;
            end
            OP_STEP: begin
              k_we   = 1'b1;
              go_seq = 1'b1;
            end
            OP_DLI: begin
              tm_val = CYC_W'(d.ticks);
              if (!delay_reachable(d.ticks, step_k)) begin
                go_bad = 1'b1;
              end else if (d.ticks == 16'd0) begin
                go_seq = 1'b1;
              end else begin
                tm_load  = 1'b1;
                nx_delay = 1'b1;
              end
            end
            OP_DLS: begin
              tm_val = steps_to_cycles(sc_b, step_k);
              if (sc_b == '0) begin
                go_seq = 1'b1;
              end else begin
                tm_load  = 1'b1;
                nx_delay = 1'b1;
              end
            end
            OP_WAIT: begin
              tm_val = steps_to_cycles(d.tmo, step_k);
              if (cond_hit) begin
                go_seq = 1'b1;
              end else if (d.tmo == '0) begin
                go_br = 1'b1;
              end else begin
                tm_load = 1'b1;
                nx_wait = 1'b1;
              end
            end
            default: go_bad = 1'b1;
          endcase
        end
      end
      ST_DELAY: begin
        if (tm_last) go_seq = 1'b1;
      end
      ST_WAIT: begin
        if (cond_hit)     go_seq = 1'b1;
        else if (tm_last) go_br  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      pc     <= '0;
      step_k <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (k_we) step_k <= d.expo;
      if (st == ST_IDLE) begin
        if (start) begin
          st    <= ST_RUN;
          pc    <= entry_pc;
          err_q <= 1'b0;
        end
      end else if (go_bad) begin
        st    <= ST_IDLE;
        err_q <= 1'b1;
      end else if (go_end) begin
        st     <= ST_IDLE;
        done_q <= 1'b1;
      end else if (go_seq || go_br) begin
        if (nx_ok) begin
          st <= ST_RUN;
          pc <= nx[PC_W-1:0];
        end else begin
          st    <= ST_IDLE;
          err_q <= 1'b1;
        end
      end else if (nx_delay) begin
        st <= ST_DELAY;
      end else if (nx_wait) begin
        st <= ST_WAIT;
      end
    end
  end

  assign imem_addr = pc;
  assign busy      = (st != ST_IDLE);
  assign done      = done_q;
  assign error     = err_q;

  assign ev_fall   = go_seq && nx_ok && !go_bad;
  assign ev_branch = go_br && nx_ok;
  assign in_delay  = (st == ST_DELAY);

endmodule

// File: rtl/pseq_engine_chk.sv
module pseq_engine_chk #(
  parameter int PC_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [PC_W-1:0] entry_pc,
  input logic [PC_W-1:0] imem_addr,
  input logic            busy,
  input logic            done,
  input logic            error,
  input logic            ev_fall,
  input logic            ev_branch,
  input logic            in_delay,
  input logic            tm_last
);

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !error));

  a_r12_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !busy);

  a_r13_err_held: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !start) |=> error);

  a_r13_start_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && imem_addr == $past(entry_pc)));

  a_r4_fall_step: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fall |=> (busy && imem_addr == PC_W'($past(imem_addr) + 1'b1)));

  a_r8_branch_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    ev_branch |=> (busy && imem_addr > $past(imem_addr)));

  a_r6_delay_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_delay && !tm_last) |=> (busy && $stable(imem_addr)));

endmodule

bind pseq_engine pseq_engine_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .entry_pc(entry_pc),
  .imem_addr(imem_addr), .busy(busy), .done(done), .error(error),
  .ev_fall(ev_fall), .ev_branch(ev_branch), .in_delay(in_delay),
  .tm_last(tm_last)
);

// File: tb/pseq_engine_test.sv
module pseq_engine_test;

  localparam int DEPTH = 64;
  localparam int PC_W  = 6;
  localparam int RA_W  = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [PC_W-1:0]  entry_pc = '0;
  logic [PC_W-1:0]  imem_addr;
  logic [31:0]      imem_rdata;
  logic [7:0]       cond_in = '0;
  logic [RA_W-1:0]  rf_raddr = '0;
  logic [7:0]       rf_rdata;
  logic             busy, done, error;

  logic [31:0] mem [DEPTH];
  int checks = 0;
  int fails = 0;
  int completions = 0;

  typedef struct {
    string tag;
    int    cyc;
    bit    dn;
    bit    er;
  } exp_t;
  exp_t sbq[$];

  always #4 clk = ~clk;

  assign imem_rdata = mem[imem_addr];

  pseq_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .entry_pc(entry_pc),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata), .cond_in(cond_in),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .busy(busy), .done(done), .error(error)
  );

  // instruction builders, written from the requirement encodings
  function automatic logic [31:0] e_gen(input logic [3:0] op, input logic [1:0] s,
                                        input logic [3:0] r, input logic [7:0] dt,
                                        input logic [7:0] mk);
    return {op, 2'b00, s, 4'h0, r, dt, mk};
  endfunction
  function automatic logic [31:0] e_wait(input logic [3:0] sel, input logic [7:0] tmo,
                                         input logic [7:0] skip);
    return {4'd9, 4'h0, sel, 4'h0, tmo, skip};
  endfunction
  function automatic logic [31:0] e_dli(input logic [15:0] c);
    return {4'd6, 12'h0, c};
  endfunction
  function automatic logic [31:0] e_step(input logic [3:0] k);
    return {4'd8, 24'h0, k};
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic chk_reg(input int a, input int exp, input string tag);
    rf_raddr = RA_W'(a);
    #1;
    check(tag, rf_rdata, exp);
  endtask

  // driver: queue the expected outcome, then pulse start
  task automatic run(input int e, input int cyc, input bit dn, input bit er,
                     input string tag);
    int n0;
    exp_t it;
    it.tag = tag; it.cyc = cyc; it.dn = dn; it.er = er;
    sbq.push_back(it);
    n0 = completions;
    @(negedge clk);
    entry_pc = PC_W'(e);
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
    wait (completions == n0 + 1);
    @(negedge clk);
    check({tag, " R11 done one cycle"}, done, 0);
  endtask

  // monitor: count busy cycles, compare on the falling edge of busy
  initial begin
    bit prev = 1'b0;
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (busy) begin
        cnt++;
      end else if (prev) begin
        exp_t it;
        it = sbq.pop_front();
        check({it.tag, " cycles"}, cnt, it.cyc);
        check({it.tag, " R11 done"}, done, it.dn);
        check({it.tag, " R12 error"}, error, it.er);
        cnt = 0;
        completions++;
      end
      prev = busy;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 32'h0;
    // R2 R3 R4 program at 0
    mem[0]  = e_gen(4'd2, 2'd0, 4'd3, 8'hA4, 8'h00);
    mem[1]  = e_gen(4'd1, 2'd0, 4'd3, 8'h01, 8'hFE);
    mem[2]  = e_gen(4'd1, 2'd0, 4'd3, 8'h3C, 8'hF0);
    mem[3]  = e_gen(4'd1, 2'd0, 4'd3, 8'hFF, 8'hFF);
    mem[4]  = e_gen(4'd1, 2'd0, 4'd4, 8'h01, 8'hFE);
    mem[5]  = e_gen(4'd2, 2'd0, 4'd7, 8'h5A, 8'h00);
    mem[6]  = e_gen(4'd2, 2'd0, 4'd7, 8'hC3, 8'h00);
    mem[7]  = 32'h0;
    // R5 scratch program at 10
    mem[10] = e_gen(4'd3, 2'd1, 4'd3, 8'h00, 8'h00);
    mem[11] = e_gen(4'd4, 2'd2, 4'd0, 8'h0F, 8'h00);
    mem[12] = e_gen(4'd2, 2'd0, 4'd5, 8'h77, 8'h00);
    mem[13] = e_gen(4'd5, 2'd2, 4'd5, 8'h00, 8'hF0);
    mem[14] = e_gen(4'd5, 2'd1, 4'd6, 8'h00, 8'h00);
    mem[15] = 32'h0;
    // R6 R7 delays at 16
    mem[16] = e_step(4'd2);
    mem[17] = e_dli(16'd12);
    mem[18] = e_gen(4'd4, 2'd3, 4'd0, 8'h03, 8'h00);
    mem[19] = e_gen(4'd7, 2'd3, 4'd0, 8'h00, 8'h00);
    mem[20] = 32'h0;
    mem[21] = e_step(4'd0);
    mem[22] = e_dli(16'd0);
    mem[23] = 32'h0;
    // R6 unreachable delays at 24 and 28
    mem[24] = e_step(4'd2);
    mem[25] = e_dli(16'd13);
    mem[26] = e_gen(4'd2, 2'd0, 4'd8, 8'h11, 8'h00);
    mem[27] = 32'h0;
    mem[28] = e_step(4'd0);
    mem[29] = e_dli(16'd300);
    mem[30] = e_gen(4'd2, 2'd0, 4'd8, 8'h22, 8'h00);
    // R8 if-test at 32, R10 jump at 37
    mem[32] = e_wait(4'd0, 8'd0, 8'd2);
    mem[33] = e_gen(4'd2, 2'd0, 4'd9, 8'h21, 8'h00);
    mem[34] = 32'h0;
    mem[35] = e_gen(4'd2, 2'd0, 4'd10, 8'h31, 8'h00);
    mem[36] = 32'h0;
    mem[37] = e_wait(4'hF, 8'd0, 8'd1);
    mem[38] = e_gen(4'd2, 2'd0, 4'd11, 8'hEE, 8'h00);
    mem[39] = e_gen(4'd2, 2'd0, 4'd12, 8'h12, 8'h00);
    mem[40] = 32'h0;
    // R9 timed wait at 41, step 2 cycles, timeout 3 steps
    mem[41] = e_step(4'd1);
    mem[42] = e_wait(4'd3, 8'd3, 8'd2);
    mem[43] = e_gen(4'd2, 2'd0, 4'd13, 8'h01, 8'h00);
    mem[44] = 32'h0;
    mem[45] = e_gen(4'd2, 2'd0, 4'd14, 8'h02, 8'h00);
    mem[46] = 32'h0;
    // R12 faults
    mem[50] = e_wait(4'hF, 8'd0, 8'd200);
    mem[51] = 32'hC000_0000;
    mem[58] = 32'h1400_0000;
    mem[63] = e_gen(4'd2, 2'd0, 4'd15, 8'h99, 8'h00);
    // R13 start during a run
    mem[52] = e_step(4'd3);
    mem[53] = e_dli(16'd40);
    mem[54] = 32'h0;
    mem[56] = e_gen(4'd2, 2'd0, 4'd1, 8'h66, 8'h00);
    mem[57] = 32'h0;

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 error", error, 0);
    chk_reg(3, 8'h00, "R1 reg3");
    chk_reg(15, 8'h00, "R1 reg15");
    rst_n = 1'b1;

    run(0, 8, 1, 0, "R2 R3 R4 writes");
    chk_reg(3, 8'hAC, "R2 masked reg3");
    chk_reg(4, 8'h01, "R2 bit0 only");
    chk_reg(7, 8'hC3, "R3 full write");

    run(10, 6, 1, 0, "R5 scratch");
    chk_reg(5, 8'h7F, "R5 masked from scratch");
    chk_reg(6, 8'hAC, "R5 read then write");

    run(16, 29, 1, 0, "R6 R7 delays");
    run(21, 3, 1, 0, "R6 zero delay");

    run(24, 2, 0, 1, "R6 not a whole step");
    chk_reg(8, 8'h00, "R6 halted after reject");
    run(28, 2, 0, 1, "R6 too many steps");
    chk_reg(8, 8'h00, "R6 halted after overflow");

    cond_in = 8'h01;
    run(32, 3, 1, 0, "R8 cond true");
    chk_reg(9, 8'h21, "R8 fall through");
    chk_reg(10, 8'h00, "R8 target skipped");
    cond_in = 8'h00;
    run(32, 3, 1, 0, "R8 cond false");
    chk_reg(10, 8'h31, "R8 branch taken");

    cond_in = 8'hFF;
    run(37, 3, 1, 0, "R10 jump");
    chk_reg(11, 8'h00, "R10 skipped write");
    chk_reg(12, 8'h12, "R10 landed");
    cond_in = 8'h00;

    run(41, 10, 1, 0, "R9 timeout");
    chk_reg(14, 8'h02, "R9 timeout branch");
    chk_reg(13, 8'h00, "R9 no fall through");
    fork
      run(41, 6, 1, 0, "R9 cond rises");
      begin
        repeat (5) @(negedge clk);
        cond_in[3] = 1'b1;
      end
    join
    chk_reg(13, 8'h01, "R9 fell through");
    cond_in = 8'h00;

    run(50, 1, 0, 1, "R12 skip past end");
    run(51, 1, 0, 1, "R12 bad opcode");
    run(58, 1, 0, 1, "R12 reserved bits");
    run(63, 1, 0, 1, "R12 last address");
    chk_reg(15, 8'h99, "R12 write kept");

    fork
      run(52, 43, 1, 0, "R13 start while busy");
      begin
        repeat (10) @(negedge clk);
        entry_pc = 6'd56;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
      end
    join
    chk_reg(1, 8'h00, "R13 second start ignored");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule